// File: doc/BRIEF.md
# External Interrupt Line Conditioner

This block sits between a set of external interrupt pins and a downstream interrupt controller that accepts only two input forms: an active-high level or a rising-edge event. Each pin is first synchronised to the block clock. The line's configuration word then selects one of four sense modes: level high, level low, rising edge or falling edge. The block turns the pin into an active-high level for the level modes, or into a one-cycle high pulse for the edge modes. With its enable bit clear, a line keeps its output low.

Software reaches the block over a simple register bus: a byte address, a write strobe, write data and combinational read data. There is one configuration word per line and one read-only status word. The status word always reports that input filtering is ready, because the block does no glitch filtering. The edge detector keeps sampling the pin while its line is disabled. Enabling a line therefore never turns an old transition into a pulse.

Top module: `xint_conditioner`

## Requirements
- R1: There are two lines. `irq_o[n]` depends only on `ext_irq_i[n]` and the configuration word of line n. The configuration word of line n is at byte address 4·(n+1), so line 0 is at 0x4 and line 1 is at 0x8.
- R2: Address 0x0 is a read-only status word that reads 0x00000001. Writes to it have no effect. Reads of any unmapped address return 0, and writes to an unmapped address change no register.
- R3: A configuration word reads back exactly the last 32-bit value written to it. Bit 16 is the enable, bit 9 selects level sensing (1) or edge sensing (0), and bit 8 is the polarity bit.
- R4: While the reset is low, and after it is released, both configuration words read 0 and both outputs are 0, whatever the pins do.
- R5: While the enable bit (bit 16) is 0, the line's output stays 0 for any pin activity.
- R6: Level-high mode (bit 9 = 1, bit 8 = 1): the output equals the pin. A pin change appears at the output on the third rising clock edge after the change.
- R7: Level-low mode (bit 9 = 1, bit 8 = 0): the output equals the inverted pin, with the same three-edge latency as R6.
- R8: Rising-edge mode (bit 9 = 0, bit 8 = 0): each 0-to-1 pin transition gives exactly one output pulse, one clock cycle wide, on the third rising edge after the change. A 1-to-0 transition gives none.
- R9: Falling-edge mode (bit 9 = 0, bit 8 = 1): each 1-to-0 pin transition gives exactly one one-cycle pulse with the R8 latency. A 0-to-1 transition gives none.
- R10: A transition that happens while the line is disabled never produces a pulse after the line is enabled in an edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 4 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ext_irq_i | input | 2 | Asynchronous external interrupt pins, one per line |
| irq_o | output | 2 | Conditioned requests to the downstream controller, one per line |

## Verification
The bench sweeps every sense mode, both enable states and both transition directions on each line. It checks the output cycle by cycle over a window around the expected edge. A wrong polarity mapping would show inverted levels or pulses on the wrong transition. An off-by-one in the synchroniser would move the output change by a cycle. An edge detector that does not clear its state would leave pulses two cycles wide. The bench also toggles a pin while its line is disabled and then enables the line. A detector that stops sampling while disabled would fire a false pulse at that point. The register checks cover writes to the status word and to unmapped addresses, full-word readback, and independence between the two lines.

// File: rtl/xint_pkg.sv
package xint_pkg;

  localparam int unsigned DATA_W      = 32;
  localparam int unsigned EN_BIT      = 16;
  localparam int unsigned LVL_BIT     = 9;
  localparam int unsigned POL_BIT     = 8;
  localparam logic [DATA_W-1:0] STATUS_READY = 32'h0000_0001;

  // Decoded per-line control fields.
  typedef struct packed {
    logic en;   // line enabled
    logic lvl;  // 1: level sense, 0: edge sense
    logic pol;  // 1: high level / falling edge, 0: low level / rising edge
  } line_cfg_t;

  function automatic line_cfg_t decode_cfg(input logic [DATA_W-1:0] word);
    line_cfg_t c;
    c.en  = word[EN_BIT];
    c.lvl = word[LVL_BIT];
    c.pol = word[POL_BIT];
    return c;
  endfunction

endpackage

// File: rtl/xint_rst_sync.sv
module xint_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  // Assert immediately, release two edges after rst_n rises.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/xint_sync.sv
module xint_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/xint_regs.sv
module xint_regs
  import xint_pkg::*;
#(
  parameter int unsigned NUM_LINES = 2,
  parameter int unsigned ADDR_W    = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic                            bus_we,
  input  logic [DATA_W-1:0]               bus_wdata,
  output logic [DATA_W-1:0]               bus_rdata,
  output logic [NUM_LINES-1:0][DATA_W-1:0] cfg_words_o
);

  localparam logic [ADDR_W-1:0] STATUS_ADDR = '0;

  logic [NUM_LINES-1:0]             sel;
  logic [NUM_LINES-1:0]             wr_en;
  logic [NUM_LINES-1:0][DATA_W-1:0] cfg_q;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_cfg
    assign sel[g] = (bus_addr == ADDR_W'(4 * (g + 1)));

    always_comb begin
      wr_en[g] = bus_we && sel[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cfg_q[g] <= '0;
      else if (wr_en[g]) cfg_q[g] <= bus_wdata;
    end

    // R3: a write lands in the addressed word unchanged
    assert_cfg_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && sel[g]) |=> (cfg_q[g] == $past(bus_wdata)));
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == STATUS_ADDR) bus_rdata = STATUS_READY;
    for (int n = 0; n < NUM_LINES; n++) begin
      if (sel[n]) bus_rdata = cfg_q[n];
    end
  end

  assign cfg_words_o = cfg_q;

  // R2: status word always reports filter ready
  assert_status_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == STATUS_ADDR) |-> (bus_rdata == STATUS_READY));

endmodule

// File: rtl/xint_line.sv
module xint_line
  import xint_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_cfg_t cfg_i,
  input  logic      sync_i,
  output logic      irq_o
);

  logic cfg_en, cfg_lvl, cfg_pol;
  logic prev_q;
  logic level_act, rise_hit, fall_hit, edge_hit;
  logic irq_d, irq_q;

  assign cfg_en  = cfg_i.en;
  assign cfg_lvl = cfg_i.lvl;
  assign cfg_pol = cfg_i.pol;

  // Next-state logic: map all four sense modes to active-high form.
  always_comb begin
    level_act = cfg_pol ? sync_i : ~sync_i;
    rise_hit  = sync_i & ~prev_q;
    fall_hit  = ~sync_i & prev_q;
    edge_hit  = cfg_pol ? fall_hit : rise_hit;
    irq_d     = cfg_en & (cfg_lvl ? level_act : edge_hit);
  end

  // Previous sample keeps tracking while disabled, so enabling is quiet.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= sync_i;
      irq_q  <= irq_d;
    end
  end

  assign irq_o = irq_q;

  // R5: a line disabled in the previous cycle drives no request
  assert_gate_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_en) |-> !irq_o);

  // R8 / R9: an edge pulse lasts one cycle while the edge mode is unchanged
  assert_pulse_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !cfg_lvl && $past(!cfg_lvl) && $stable(cfg_pol)) |=> !irq_o);

endmodule

// File: rtl/xint_conditioner.sv
module xint_conditioner
  import xint_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 2,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_LINES-1:0] ext_irq_i,
  output logic [NUM_LINES-1:0] irq_o
);

  logic                             rst_n_sync;
  logic [NUM_LINES-1:0][DATA_W-1:0] cfg_words;
  logic [NUM_LINES-1:0]             pin_sync;

  xint_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  xint_regs #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .cfg_words_o (cfg_words)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    line_cfg_t line_cfg;

    assign line_cfg = decode_cfg(cfg_words[g]);

    xint_sync #(
      .STAGES (SYNC_STAGES)
    ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n_sync),
      .async_i (ext_irq_i[g]),
      .sync_o  (pin_sync[g])
    );

    xint_line u_line (
      .clk    (clk),
      .rst_n  (rst_n_sync),
      .cfg_i  (line_cfg),
      .sync_i (pin_sync[g]),
      .irq_o  (irq_o[g])
    );
  end

endmodule

// File: tb/xint_conditioner_tb.sv
module xint_conditioner_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [1:0]  ext_irq_i;
  logic [1:0]  irq_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  xint_conditioner u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ext_irq_i (ext_irq_i),
    .irq_o     (irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cfg_word(input bit en, input bit lvl, input bit pol);
    return (32'(en) << 16) | (32'(lvl) << 9) | (32'(pol) << 8);
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 4'h0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
    bus_addr = 4'h0;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_addr = 4'h0; bus_we = 1'b0; bus_wdata = '0;
    ext_irq_i = 2'b11;
    repeat (4) @(negedge clk);
    chk("R4 outputs in reset", 32'(irq_o), 32'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R4 outputs after reset", 32'(irq_o), 32'h0);
    rd_chk("R4 cfg0 reset", 4'h4, 32'h0);
    rd_chk("R4 cfg1 reset", 4'h8, 32'h0);
    rd_chk("R2 status", 4'h0, 32'h1);
    ext_irq_i = 2'b00;

    // Register map checks
    wr(4'h4, 32'hFFFF_FFFF);
    rd_chk("R3 full readback line0", 4'h4, 32'hFFFF_FFFF);
    rd_chk("R1 line1 untouched", 4'h8, 32'h0);
    wr(4'h8, 32'hA5A5_0100);
    rd_chk("R3 readback line1", 4'h8, 32'hA5A5_0100);
    rd_chk("R1 line0 untouched", 4'h4, 32'hFFFF_FFFF);
    wr(4'h0, 32'h0000_0000);
    rd_chk("R2 status write ignored", 4'h0, 32'h1);
    wr(4'hC, 32'h1234_5678);
    rd_chk("R2 unmapped reads zero", 4'hC, 32'h0);
    rd_chk("R2 unmapped write line0", 4'h4, 32'hFFFF_FFFF);
    rd_chk("R2 unmapped write line1", 4'h8, 32'hA5A5_0100);
    wr(4'h4, 32'h0);
    wr(4'h8, 32'h0);
    repeat (4) @(negedge clk);

    // Sweep: line x mode x enable x direction, cycle by cycle
    for (int ln = 0; ln < 2; ln++) begin
      for (int m = 0; m < 4; m++) begin
        for (int en = 0; en < 2; en++) begin
          bit lvl, pol;
          string req;
          lvl = m[1]; pol = m[0];
          req = (en == 0) ? "R5" : (lvl ? (pol ? "R6" : "R7") : (pol ? "R9" : "R8"));
          ext_irq_i = 2'b00;
          wr(4'(4 * (ln + 1)), cfg_word(en[0], lvl, pol));
          repeat (6) @(negedge clk);
          for (int step = 0; step < 2; step++) begin
            bit newv;
            newv = (step == 0);
            ext_irq_i[ln] = newv;
            for (int k = 1; k <= 6; k++) begin
              bit v, e;
              @(negedge clk);
              v = (k >= 3) ? newv : ~newv;
              if (en == 0)  e = 1'b0;
              else if (lvl) e = pol ? v : ~v;
              else          e = (k == 3) && (pol ? !newv : newv);
              chk(req, 32'(irq_o[ln]), 32'(e));
              chk("R1 other line quiet", 32'(irq_o[1-ln]), 32'h0);
            end
          end
          wr(4'(4 * (ln + 1)), 32'h0);
          ext_irq_i = 2'b00;
          repeat (4) @(negedge clk);
        end
      end
    end

    // R1: lines configured differently, only line0 pin moves
    wr(4'h4, cfg_word(1, 1, 1));
    wr(4'h8, cfg_word(1, 0, 0));
    repeat (4) @(negedge clk);
    ext_irq_i[0] = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      chk("R1 line0 level", 32'(irq_o[0]), 32'(k >= 3));
      chk("R1 line1 unaffected", 32'(irq_o[1]), 32'h0);
    end
    ext_irq_i[0] = 1'b0;
    wr(4'h4, 32'h0);
    wr(4'h8, 32'h0);
    repeat (4) @(negedge clk);

    // R10: transitions while disabled leave no pulse after enabling
    wr(4'h4, cfg_word(0, 0, 0));
    ext_irq_i[0] = 1'b1;
    repeat (6) @(negedge clk);
    wr(4'h4, cfg_word(1, 0, 0));
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk("R10 rising enable quiet", 32'(irq_o[0]), 32'h0);
    end
    wr(4'h4, cfg_word(0, 0, 1));
    ext_irq_i[0] = 1'b0;
    repeat (6) @(negedge clk);
    wr(4'h4, cfg_word(1, 0, 1));
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk("R10 falling enable quiet", 32'(irq_o[0]), 32'h0);
    end
    // Enabled afterwards, a real transition still pulses once (R9)
    ext_irq_i[0] = 1'b1;
    repeat (6) @(negedge clk);
    ext_irq_i[0] = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      chk("R9 after enable", 32'(irq_o[0]), 32'(k == 3));
    end

    finish_run();
  end

endmodule